// File: doc/BRIEF.md
# I2C Serial Clock and Data-Hold Timer

This block derives the serial clock for an I2C master from the system clock. An 8-bit rate word selects two things. Its upper two bits give a multiplier of 1, 2 or 4. Its lower six bits index a computed lookup that yields a base divider and a data-hold count. The serial clock period is the multiplier times the base divider, in system clock cycles. Each period begins with the serial clock falling low and ends with it high. A one-cycle data-update strobe fires a fixed number of cycles after each falling edge: the hold count times the multiplier. A one-cycle tick marks the last cycle of every period.

A byte engine placed after this block uses the strobe to change the data line and the tick to advance its bit counter. Start and stop sequencing, shifting, arbitration, clock stretching and pad drivers are outside this block. A rate word written while the clock runs takes effect at the next period boundary. While the enable is low, the rate word is taken at once and the outputs stay idle. A reserved multiplier code runs as ×1 and sets a sticky error flag.

Top module: `i2c_sclk_timer`

## Requirements
- R1: During reset, and after it until the first enabled period, scl_out is 1 and sda_strobe and bit_tick are 0. Reset clears cfg_err to 0.
- R2: rate_word[7:6] is the multiplier code: 00 gives ×1, 01 gives ×2 and 10 gives ×4. rate_word[5:0] is the rate index.
- R3: With the default parameters, the base divider for index i is 18 + 2·i, so index 0x0B gives 40. One serial clock period lasts multiplier × divider cycles.
- R4: Within a period of P cycles, scl_out is 0 for the first P/2 cycles and 1 for the remaining P/2 cycles. The clock then falls again.
- R5: bit_tick is a one-cycle pulse on the last cycle of every period and is 0 otherwise.
- R6: sda_strobe is a one-cycle pulse exactly multiplier × (4 + i/2) cycles after each falling edge, with integer division. Index 0x0B gives a hold count of 9.
- R7: Multiplier code 11 runs as ×1. Loading it sets cfg_err, which stays 1 until reset.
- R8: A rate_word change made while the clock runs takes effect only at the next period boundary.
- R9: Once enable is sampled low, the next clock edge returns the outputs to idle (scl_out 1, no pulses). Once enable is sampled high from idle, scl_out falls at the next edge, starting a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the serial clock when high |
| rate_word | input | 8 | Multiplier code [7:6] and rate index [5:0] |
| scl_out | output | 1 | Serial clock level |
| sda_strobe | output | 1 | One-cycle pulse at the data-change point |
| bit_tick | output | 1 | One-cycle pulse on the last cycle of each period |
| cfg_err | output | 1 | Sticky flag set when the reserved multiplier code is loaded |

## Verification
A wrong phase count or a wrong latched divider shows up within one serial clock period. The high phase starts on the wrong cycle, or the tick lands at the wrong spot, so the period length changes. A wrong hold value moves the strobe away from its fixed offset after the falling edge. This also shows before the next falling edge. A config register that reloads at the wrong moment shows up as a period of the wrong length right after a mid-period rate change. A stuck run flag shows up one cycle after an enable change, as a clock that does not idle high or does not fall.

// File: rtl/i2c_sclk_pkg.sv
// Package: multiplier code type and helper shared by the timer modules.
// Assumes: code 11 is reserved and is run as x1.
package i2c_sclk_pkg;

    typedef enum logic [1:0] {
        MUL_X1  = 2'b00,
        MUL_X2  = 2'b01,
        MUL_X4  = 2'b10,
        MUL_RSV = 2'b11
    } mul_code_e;

    // Left shift that applies the multiplier for a code.
    function automatic logic [1:0] mul_shift(input mul_code_e code);
        case (code)
            MUL_X2:  mul_shift = 2'd1;
            MUL_X4:  mul_shift = 2'd2;
            default: mul_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_rate_decode.sv
// Module: i2c_rate_decode
// Turns a rate word into the cycle counts of one serial clock period:
// the last count, the count where the high phase begins, and the count
// where the data strobe fires. The divider and hold tables are computed
// from the index, so no table is stored.
// Assumes: DIV_BASE, DIV_STEP are even, so the period is even, and hold
// counts stay below half the divider for every index.
module i2c_rate_decode
    import i2c_sclk_pkg::*;
#(
    parameter int DIV_BASE  = 18,
    parameter int DIV_STEP  = 2,
    parameter int HOLD_BASE = 4,
    parameter int CNT_W     = 10
) (
    input  logic [7:0]       rate_word,
    output logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] hold_cnt,
    output logic             reserved
);

    logic [5:0]       idx;
    logic [1:0]       sh;
    logic [CNT_W-1:0] div_base;
    logic [CNT_W-1:0] hold_base;
    logic [CNT_W-1:0] period;

    // Split the word into fields and build the scaled counts.
    always_comb begin
        idx       = rate_word[5:0];
        sh        = mul_shift(mul_code_e'(rate_word[7:6]));
        div_base  = CNT_W'(DIV_BASE) + CNT_W'(DIV_STEP) * CNT_W'(idx);
        hold_base = CNT_W'(HOLD_BASE) + CNT_W'(idx >> 1);
        period    = div_base << sh;
        last_cnt  = period - CNT_W'(1);
        high_cnt  = period >> 1;
        hold_cnt  = hold_base << sh;
        reserved  = (rate_word[7:6] == MUL_RSV);
    end

endmodule

// File: rtl/i2c_phase_counter.sv
// Module: i2c_phase_counter
// Counts cycles within a serial clock period and decodes the clock level,
// data strobe and period tick. New counts are taken when idle, on the
// first enabled cycle and at each period boundary.
// Assumes: hold_cnt lies strictly between 0 and high_cnt.
module i2c_phase_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] last_cnt_n,
    input  logic [CNT_W-1:0] high_cnt_n,
    input  logic [CNT_W-1:0] hold_cnt_n,
    output logic             cfg_load,
    output logic             scl_out,
    output logic             sda_strobe,
    output logic             bit_tick
);

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] high_q;
    logic [CNT_W-1:0] hold_q;
    logic             at_end;

    // Find the last cycle of a period and the moments that take new counts.
    always_comb begin
        at_end   = run && (cnt == last_q);
        cfg_load = rst_n && (!enable || !run || at_end);
    end

    // Advance the phase counter and latch the active counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            last_q <= '0;
            high_q <= '0;
            hold_q <= '0;
        end else begin
            run <= enable;
            if (cfg_load) begin
                cnt    <= '0;
                last_q <= last_cnt_n;
                high_q <= high_cnt_n;
                hold_q <= hold_cnt_n;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Decode the output levels and pulses from the count.
    always_comb begin
        scl_out    = !run || (cnt >= high_q);
        sda_strobe = run && (cnt == hold_q);
        bit_tick   = at_end;
    end

endmodule

// File: rtl/i2c_sclk_timer.sv
// Module: i2c_sclk_timer (top)
// Serial clock and data-hold timer for an I2C master. It decodes the rate
// word, runs the phase counter and keeps the sticky reserved-code flag.
// Assumes: synchronous active-low reset; rate_word may change at any time.
module i2c_sclk_timer #(
    parameter int DIV_BASE  = 18,
    parameter int DIV_STEP  = 2,
    parameter int HOLD_BASE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [7:0] rate_word,
    output logic       scl_out,
    output logic       sda_strobe,
    output logic       bit_tick,
    output logic       cfg_err
);

    localparam int MAX_DIV    = DIV_BASE + DIV_STEP * 63;
    localparam int MAX_PERIOD = 4 * MAX_DIV;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic             reserved;
    logic             cfg_load;

    i2c_rate_decode #(
        .DIV_BASE (DIV_BASE),
        .DIV_STEP (DIV_STEP),
        .HOLD_BASE(HOLD_BASE),
        .CNT_W    (CNT_W)
    ) u_decode (
        .rate_word(rate_word),
        .last_cnt (last_cnt),
        .high_cnt (high_cnt),
        .hold_cnt (hold_cnt),
        .reserved (reserved)
    );

    i2c_phase_counter #(
        .CNT_W(CNT_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .last_cnt_n(last_cnt),
        .high_cnt_n(high_cnt),
        .hold_cnt_n(hold_cnt),
        .cfg_load  (cfg_load),
        .scl_out   (scl_out),
        .sda_strobe(sda_strobe),
        .bit_tick  (bit_tick)
    );

    // Set the error flag when a reserved code is taken; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (cfg_load && reserved) begin
            cfg_err <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_sclk_timer_chk.sv
// Module: i2c_sclk_timer_chk
// Port-level temporal checks for i2c_sclk_timer, bound to every instance.
module i2c_sclk_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [7:0] rate_word,
    input logic       scl_out,
    input logic       sda_strobe,
    input logic       bit_tick,
    input logic       cfg_err
);

    // R9 / R1: a cycle after enable was low, all outputs are idle.
    assert_idle_after_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_out && !sda_strobe && !bit_tick));

    // R6: the data strobe falls inside the low phase.
    assert_strobe_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_strobe |-> !scl_out);

    // R5: the tick comes in the high phase, never with the strobe.
    assert_tick_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (scl_out && !sda_strobe));

    // R4: after a tick with enable still high, the clock is low.
    assert_fall_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable) |=> !scl_out);

    // R7: the error flag never clears without reset.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R7: a reserved code taken while idle sets the flag.
    assert_err_on_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && rate_word[7:6] == 2'b11) |=> cfg_err);

endmodule

bind i2c_sclk_timer i2c_sclk_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rate_word (rate_word),
    .scl_out   (scl_out),
    .sda_strobe(sda_strobe),
    .bit_tick  (bit_tick),
    .cfg_err   (cfg_err)
);

// File: tb/i2c_sclk_timer_test.sv
// Bench for i2c_sclk_timer: a table of rate words run through one loop,
// then directed tests for reset, disable, rate change and the error flag.
module i2c_sclk_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] rate_word = 8'h00;
    logic       scl_out, sda_strobe, bit_tick, cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    i2c_sclk_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rate_word (rate_word),
        .scl_out   (scl_out),
        .sda_strobe(sda_strobe),
        .bit_tick  (bit_tick),
        .cfg_err   (cfg_err)
    );

    localparam int NVEC = 7;
    localparam logic [7:0] VEC [NVEC] = '{8'h4B, 8'h00, 8'h3F, 8'h80, 8'hC5, 8'h8B, 8'h21};

    // Expected model taken from the requirements.
    function automatic int mulf(input logic [7:0] w);
        case (w[7:6])
            2'b01:   mulf = 2;
            2'b10:   mulf = 4;
            default: mulf = 1;
        endcase
    endfunction
    function automatic int per(input logic [7:0] w);
        per = mulf(w) * (18 + 2 * int'(w[5:0]));
    endfunction
    function automatic int hld(input logic [7:0] w);
        hld = mulf(w) * (4 + int'(w[5:0]) / 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Enable with word a, change to b at k=2, observe n cycles from the first fall.
    task automatic run_cfg(input logic [7:0] a, input logic [7:0] b, input int n, input string tag);
        int pa, pb, ph, p, h;
        int bad_scl, bad_stb, bad_tck, k_scl, k_stb, k_tck;
        bad_scl = 0; bad_stb = 0; bad_tck = 0; k_scl = -1; k_stb = -1; k_tck = -1;
        enable = 1'b0;
        rate_word = a;
        @(negedge clk);
        enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pa = per(a);
        pb = per(b);
        for (int k = 0; k < n; k++) begin
            if (k < pa) begin
                ph = k; p = pa; h = hld(a);
            end else begin
                ph = (k - pa) % pb; p = pb; h = hld(b);
            end
            if (scl_out !== (ph >= p / 2)) begin bad_scl++; if (k_scl < 0) k_scl = k; end
            if (sda_strobe !== (ph == h)) begin bad_stb++; if (k_stb < 0) k_stb = k; end
            if (bit_tick !== (ph == p - 1)) begin bad_tck++; if (k_tck < 0) k_tck = k; end
            if (k == 2) rate_word = b;
            @(negedge clk);
        end
        check(bad_scl == 0, {tag, " R4 scl level (first bad cycle)"}, k_scl, -1);
        check(bad_stb == 0, {tag, " R6 strobe (first bad cycle)"}, k_stb, -1);
        check(bad_tck == 0, {tag, " R5 tick (first bad cycle)"}, k_tck, -1);
        enable = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int lo, hi, first;
        // R1: state during reset.
        repeat (3) @(negedge clk);
        check(scl_out === 1'b1, "R1 scl in reset", scl_out, 1);
        check(sda_strobe === 1'b0 && bit_tick === 1'b0, "R1 pulses in reset", sda_strobe | bit_tick, 0);
        check(cfg_err === 1'b0, "R1 cfg_err in reset", cfg_err, 0);
        rst_n = 1'b1;

        // R1 R9: idle while disabled.
        lo = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!scl_out || sda_strobe || bit_tick) lo++;
        end
        check(lo == 0, "R9 R1 idle while disabled (bad cycles)", lo, 0);
        check(cfg_err === 1'b0, "R7 no error before reserved code", cfg_err, 0);

        // R2 R3 R4 R5 R6: table of rate words, each over two periods.
        for (int v = 0; v < NVEC; v++) begin
            run_cfg(VEC[v], VEC[v], 2 * per(VEC[v]) + 2, $sformatf("R2 R3 vec%0d", v));
        end

        // R3 R6: index 0x0B at x2 measured directly: 40 cycles low, 40 high, strobe at 18.
        enable = 1'b0; rate_word = 8'h4B;
        @(negedge clk); enable = 1'b1; @(posedge clk); @(negedge clk);
        lo = 0; hi = 0; first = -1;
        for (int k = 0; k < 80; k++) begin
            if (scl_out) hi++; else lo++;
            if (sda_strobe && first < 0) first = k;
            @(negedge clk);
        end
        check(lo == 40, "R3 low cycles for 0x4B", lo, 40);
        check(hi == 40, "R3 high cycles for 0x4B", hi, 40);
        check(first == 18, "R6 strobe offset for 0x4B", first, 18);

        // R9: disable mid-period returns to idle at the next edge.
        enable = 1'b0;
        @(negedge clk);
        lo = 0;
        for (int k = 0; k < 30; k++) begin
            if (!scl_out || sda_strobe || bit_tick) lo++;
            @(negedge clk);
        end
        check(lo == 0, "R9 idle after disable (bad cycles)", lo, 0);

        // R8: change from 0x00 to 0x4B at k=2 applies at the boundary.
        run_cfg(8'h00, 8'h4B, 18 + 2 * 80, "R8 change");

        // R7: reserved code sets a sticky flag; reset clears it.
        check(cfg_err === 1'b1, "R7 flag set after reserved vector", cfg_err, 1);
        rate_word = 8'h0B;
        repeat (5) @(negedge clk);
        check(cfg_err === 1'b1, "R7 flag stays set", cfg_err, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_err === 1'b0, "R1 R7 flag cleared by reset", cfg_err, 0);
        rate_word = 8'hC0;
        @(negedge clk);
        check(cfg_err === 1'b1, "R7 flag set while disabled", cfg_err, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule